// File: doc/BRIEF.md
# Row/Column Multiplexed DRAM Sequencer With Refresh

This block turns single-word read and write requests into the strobe sequence of a dynamic memory array holding 2048 rows of 2048 four-bit cells. A request carries a 22-bit word address, a write flag and a four-bit write value. The address is split into a row half and a column half, and the two halves go out one after the other on one shared 11-bit address bus. The row is strobed first, and the column follows.

A cell loses its charge when it is read, so the array must restore an open row before that row closes. Cells also leak over time. For this reason, the block has a refresh engine. An interval timer raises a refresh request at a fixed rate. A row counter names the next row to restore. Refresh is a row strobe with no column strobe. When refresh and an access compete, refresh wins, and `req_ready` stays low until the refresh has finished. The bidirectional data pins are split into a drive value, a drive enable and a sampled input, so that the pad cell can sit outside the block.

Top module: `dram_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are 1, and `dram_dq_oe` and `rd_valid` are 0.
- R2: In the cycle after a request is accepted (`req_valid` and `req_ready` both 1), `dram_ras_n` is 0, `dram_cas_n` is 1, and `dram_addr` carries the row, which is `req_addr[21:11]`.
- R3: In the second and third cycles after acceptance, `dram_ras_n` and `dram_cas_n` are both 0, and `dram_addr` carries the column, which is `req_addr[10:0]`.
- R4: In those two column cycles, a write drives `dram_we_n`=0, `dram_oe_n`=1, `dram_dq_oe`=1 and `dram_dq_out` equal to the write value. A read drives `dram_oe_n`=0, `dram_we_n`=1 and `dram_dq_oe`=0. `dram_we_n` and `dram_oe_n` are never 0 together.
- R5: For a read, `rd_valid` is 1 for exactly one cycle, the fourth cycle after acceptance. In that cycle, `rd_data` holds the value last written to that address, or 0 if the address was never written.
- R6: In the fourth cycle after acceptance, all four strobes are 1. The fifth cycle is idle. `dram_cas_n` never falls unless `dram_ras_n` was 0 in the cycle before.
- R7: `req_ready` is 1 only when the block is idle and no refresh is pending. While `req_ready` is 1, all strobes are 1. A request presented while `req_ready` is 0 is dropped: it starts no strobe activity and writes nothing.
- R8: The refresh request rises once every REFRESH_INTERVAL clock cycles, counted from reset. A pending refresh is served from the next idle cycle, ahead of any request. If a new interval ends in the cycle where a refresh completes, the refresh request stays pending.
- R9: A refresh holds `dram_ras_n` at 0 for two cycles and then holds all strobes at 1 for one cycle. During a refresh, `dram_cas_n`, `dram_we_n` and `dram_oe_n` stay 1 and `req_ready` is 0.
- R10: The first refresh after reset uses row 0. Each later refresh uses the next row, and the row number wraps from 2047 back to 0.
- R11: `dram_cas_n` is 0 only while `dram_ras_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address; the upper 11 bits are the row and the lower 11 bits are the column |
| req_wdata | input | 4 | Write value |
| req_ready | output | 1 | The request is taken this cycle if `req_valid` is 1 |
| rd_valid | output | 1 | One-cycle pulse that marks read data |
| rd_data | output | 4 | Read value |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write select, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 4 | Value driven onto the data pins |
| dram_dq_oe | output | 1 | Drive enable for the data pins |
| dram_dq_in | input | 4 | Value sampled from the data pins |

## Verification
The assertions check, on every cycle, the relations that hold at any time:
- the column strobe only inside a row strobe;
- write and output enables never active together;
- data driven only with write select;
- idle strobes whenever ready is high;
- the single-cycle read pulse;
- the row strobe right after acceptance;
- no column strobe and no ready during refresh;
- the refresh row stepping by one and wrapping at 2047.

Only the bench's scenarios can show the rest, because these behaviours need the history of requests, values and time:
- the row and column halves taken from the requested address;
- read data matching earlier writes through an array model;
- requests presented while not ready having no effect;
- refresh starting at the exact interval and taking priority;
- a full sweep of all 2048 rows.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ROW   = 3'd1,
    ST_COL   = 3'd2,
    ST_DATA  = 3'd3,
    ST_PRE   = 3'd4,
    ST_RROW  = 3'd5,
    ST_RHOLD = 3'd6,
    ST_RPRE  = 3'd7
  } seq_state_t;

  // Row strobe is low while a row is open: during an access or a refresh.
  function automatic logic row_open(input seq_state_t s);
    return (s == ST_ROW) || (s == ST_COL) || (s == ST_DATA) ||
           (s == ST_RROW) || (s == ST_RHOLD);
  endfunction

  // Column strobe is low during the two column phases of an access.
  function automatic logic col_open(input seq_state_t s);
    return (s == ST_COL) || (s == ST_DATA);
  endfunction

  function automatic logic in_refresh(input seq_state_t s);
    return (s == ST_RROW) || (s == ST_RHOLD) || (s == ST_RPRE);
  endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int INTERVAL = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic refresh_done,
  output logic refresh_pending
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt             <= '0;
      refresh_pending <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      // A new interval ending wins over completion, so no tick is lost.
      if (tick)              refresh_pending <= 1'b1;
      else if (refresh_done) refresh_pending <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_refresh_row.sv
module dram_refresh_row #(
  parameter int ROW_BITS = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  output logic [ROW_BITS-1:0] row
);
  // The row count is a power of two, so the counter wraps to 0 by itself.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row <= '0;
    else if (step) row <= row + 1'b1;
  end
endmodule

// File: rtl/dram_access_fsm.sv
module dram_access_fsm
  import dram_seq_pkg::*;
#(
  parameter int ROW_BITS  = 11,
  parameter int COL_BITS  = 11,
  parameter int DATA_BITS = 4,
  localparam int ADDR_BITS = ROW_BITS + COL_BITS,
  localparam int PIN_BITS  = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_BITS-1:0] req_addr,
  input  logic [DATA_BITS-1:0] req_wdata,
  input  logic                 refresh_pending,
  input  logic [ROW_BITS-1:0]  refresh_row,
  output logic                 req_ready,
  output logic                 rd_valid,
  output logic [DATA_BITS-1:0] rd_data,
  output logic [PIN_BITS-1:0]  dram_addr,
  output logic                 dram_ras_n,
  output logic                 dram_cas_n,
  output logic                 dram_we_n,
  output logic                 dram_oe_n,
  output logic [DATA_BITS-1:0] dram_dq_out,
  output logic                 dram_dq_oe,
  input  logic [DATA_BITS-1:0] dram_dq_in,
  output logic                 refresh_busy,
  output logic                 refresh_step
);

  function automatic logic [ROW_BITS-1:0] row_part(input logic [ADDR_BITS-1:0] a);
    return a[ADDR_BITS-1:COL_BITS];
  endfunction

  function automatic logic [COL_BITS-1:0] col_part(input logic [ADDR_BITS-1:0] a);
    return a[COL_BITS-1:0];
  endfunction

  seq_state_t           state, nxt;
  logic [ROW_BITS-1:0]  lat_row;
  logic [COL_BITS-1:0]  lat_col;
  logic                 lat_wr;
  logic [DATA_BITS-1:0] lat_wdata;
  logic                 accept;
  logic                 col_phase;

  assign req_ready = (state == ST_IDLE) && !refresh_pending;
  assign accept    = req_ready && req_valid;
  assign col_phase = col_open(state);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: begin
        if (refresh_pending) nxt = ST_RROW;
        else if (req_valid)  nxt = ST_ROW;
      end
      ST_ROW:   nxt = ST_COL;
      ST_COL:   nxt = ST_DATA;
      ST_DATA:  nxt = ST_PRE;
      ST_PRE:   nxt = ST_IDLE;
      ST_RROW:  nxt = ST_RHOLD;
      ST_RHOLD: nxt = ST_RPRE;
      ST_RPRE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lat_row   <= '0;
      lat_col   <= '0;
      lat_wr    <= 1'b0;
      lat_wdata <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      state <= nxt;
      if (accept) begin
        lat_row   <= row_part(req_addr);
        lat_col   <= col_part(req_addr);
        lat_wr    <= req_write;
        lat_wdata <= req_wdata;
      end
      // Sample the array at the end of the second column cycle.
      rd_valid <= (state == ST_DATA) && !lat_wr;
      if ((state == ST_DATA) && !lat_wr) rd_data <= dram_dq_in;
    end
  end

  always_comb begin
    dram_ras_n  = !row_open(state);
    dram_cas_n  = !col_phase;
    dram_we_n   = !(col_phase && lat_wr);
    dram_oe_n   = !(col_phase && !lat_wr);
    dram_dq_oe  = col_phase && lat_wr;
    dram_dq_out = lat_wdata;
    case (state)
      ST_ROW:            dram_addr = PIN_BITS'(lat_row);
      ST_COL, ST_DATA:   dram_addr = PIN_BITS'(lat_col);
      ST_RROW, ST_RHOLD: dram_addr = PIN_BITS'(refresh_row);
      default:           dram_addr = '0;
    endcase
  end

  assign refresh_busy = in_refresh(state);
  assign refresh_step = (state == ST_RPRE);

endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl #(
  parameter int ROW_BITS         = 11,
  parameter int COL_BITS         = 11,
  parameter int DATA_BITS        = 4,
  parameter int REFRESH_INTERVAL = 64,
  localparam int ADDR_BITS = ROW_BITS + COL_BITS,
  localparam int PIN_BITS  = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_BITS-1:0] req_addr,
  input  logic [DATA_BITS-1:0] req_wdata,
  output logic                 req_ready,
  output logic                 rd_valid,
  output logic [DATA_BITS-1:0] rd_data,
  output logic [PIN_BITS-1:0]  dram_addr,
  output logic                 dram_ras_n,
  output logic                 dram_cas_n,
  output logic                 dram_we_n,
  output logic                 dram_oe_n,
  output logic [DATA_BITS-1:0] dram_dq_out,
  output logic                 dram_dq_oe,
  input  logic [DATA_BITS-1:0] dram_dq_in
);

  // Internal events, named for the bound checker.
  logic                refresh_pending;
  logic                refresh_busy;
  logic                refresh_step;
  logic [ROW_BITS-1:0] refresh_row;

  dram_refresh_timer #(.INTERVAL(REFRESH_INTERVAL)) u_timer (
    .clk             (clk),
    .rst_n           (rst_n),
    .refresh_done    (refresh_step),
    .refresh_pending (refresh_pending)
  );

  dram_refresh_row #(.ROW_BITS(ROW_BITS)) u_rowctr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (refresh_step),
    .row   (refresh_row)
  );

  dram_access_fsm #(
    .ROW_BITS  (ROW_BITS),
    .COL_BITS  (COL_BITS),
    .DATA_BITS (DATA_BITS)
  ) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_write       (req_write),
    .req_addr        (req_addr),
    .req_wdata       (req_wdata),
    .refresh_pending (refresh_pending),
    .refresh_row     (refresh_row),
    .req_ready       (req_ready),
    .rd_valid        (rd_valid),
    .rd_data         (rd_data),
    .dram_addr       (dram_addr),
    .dram_ras_n      (dram_ras_n),
    .dram_cas_n      (dram_cas_n),
    .dram_we_n       (dram_we_n),
    .dram_oe_n       (dram_oe_n),
    .dram_dq_out     (dram_dq_out),
    .dram_dq_oe      (dram_dq_oe),
    .dram_dq_in      (dram_dq_in),
    .refresh_busy    (refresh_busy),
    .refresh_step    (refresh_step)
  );

endmodule

// File: rtl/dram_seq_checker.sv
module dram_seq_checker #(
  parameter int ROW_BITS = 11
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                rd_valid,
  input logic                dram_ras_n,
  input logic                dram_cas_n,
  input logic                dram_we_n,
  input logic                dram_oe_n,
  input logic                dram_dq_oe,
  input logic                refresh_busy,
  input logic                refresh_step,
  input logic [ROW_BITS-1:0] refresh_row
);
  localparam logic [ROW_BITS-1:0] LAST_ROW = '1;

  assert_cas_inside_ras_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);

  assert_we_oe_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dram_we_n && !dram_oe_n));

  assert_drive_with_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> !dram_we_n);

  assert_ready_idle_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n));

  assert_read_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_accept_opens_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!dram_ras_n && dram_cas_n));

  assert_row_before_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> !$past(dram_ras_n));

  assert_refresh_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_busy |-> (dram_cas_n && dram_we_n && dram_oe_n && !req_ready));

  assert_refresh_advance_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_step && refresh_row != LAST_ROW) |=> (refresh_row == $past(refresh_row) + 1'b1));

  assert_refresh_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_step && refresh_row == LAST_ROW) |=> (refresh_row == '0));

  assert_row_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_step |=> $stable(refresh_row));

endmodule

bind dram_seq_ctrl dram_seq_checker #(.ROW_BITS(ROW_BITS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rd_valid     (rd_valid),
  .dram_ras_n   (dram_ras_n),
  .dram_cas_n   (dram_cas_n),
  .dram_we_n    (dram_we_n),
  .dram_oe_n    (dram_oe_n),
  .dram_dq_oe   (dram_dq_oe),
  .refresh_busy (refresh_busy),
  .refresh_step (refresh_step),
  .refresh_row  (refresh_row)
);

// File: tb/dram_seq_ctrl_test.sv
module dram_seq_ctrl_test;
  localparam int IV    = 16;
  localparam int NROWS = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [3:0]  rd_data;
  logic [10:0] dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
  logic [3:0]  dram_dq_out;
  logic        dram_dq_oe;
  logic [3:0]  dram_dq_in = '0;

  always #5 clk = ~clk;

  dram_seq_ctrl #(.REFRESH_INTERVAL(IV)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // ---------------- behavioural array ----------------
  logic [3:0] arr [int];
  int open_row = 0;

  always @(negedge clk) begin
    if (!dram_ras_n && dram_cas_n) open_row = int'(dram_addr);
    if (!dram_cas_n && !dram_we_n && dram_dq_oe)
      arr[open_row * NROWS + int'(dram_addr)] = dram_dq_out;
    if (!dram_cas_n && !dram_oe_n) begin
      if (arr.exists(open_row * NROWS + int'(dram_addr)))
        dram_dq_in <= arr[open_row * NROWS + int'(dram_addr)];
      else
        dram_dq_in <= 4'h0;
    end
  end

  // ---------------- reference model ----------------
  typedef struct {
    logic       ras_n, cas_n, we_n, oe_n;
    logic       is_ref;
    logic       chk_addr;
    logic [10:0] addr;
    logic       dq_oe;
    logic [3:0] dq;
    logic       rdv;
    logic [3:0] rdd;
  } vec_t;

  vec_t       q[$];
  logic [3:0] mm [int];
  int  cyc = 0;
  bit  m_pend = 0;
  int  clr_at = -1;
  int  m_rrow = 0;
  int  n_wraps = 0;

  function automatic vec_t quiet();
    vec_t v;
    v.ras_n = 1; v.cas_n = 1; v.we_n = 1; v.oe_n = 1;
    v.is_ref = 0; v.chk_addr = 0; v.addr = '0;
    v.dq_oe = 0; v.dq = '0; v.rdv = 0; v.rdd = '0;
    return v;
  endfunction

  always @(negedge clk) begin
    vec_t e, v;
    bit busy;
    int key;
    if (rst_n && !finished) begin
      busy = (q.size() > 0);
      if (busy) e = q.pop_front(); else e = quiet();
      // Strobes: R9 inside refresh, R6 otherwise
      if (e.is_ref) begin
        chk("R9", "ras_n", dram_ras_n, e.ras_n);
        chk("R9", "cas_n", dram_cas_n, e.cas_n);
        chk("R9", "we_n", dram_we_n, e.we_n);
        chk("R9", "oe_n", dram_oe_n, e.oe_n);
      end else begin
        chk("R6", "ras_n", dram_ras_n, e.ras_n);
        chk("R3", "cas_n", dram_cas_n, e.cas_n);
        chk("R4", "we_n", dram_we_n, e.we_n);
        chk("R4", "oe_n", dram_oe_n, e.oe_n);
      end
      chk("R4", "dq_oe", dram_dq_oe, e.dq_oe);
      if (e.dq_oe) chk("R4", "dq_out", dram_dq_out, e.dq);
      if (e.chk_addr) begin
        if (e.is_ref) chk("R10", "refresh row", dram_addr, e.addr);
        else if (e.cas_n) chk("R2", "row addr", dram_addr, e.addr);
        else chk("R3", "col addr", dram_addr, e.addr);
      end
      chk("R5", "rd_valid", rd_valid, e.rdv);
      if (e.rdv) chk("R5", "rd_data", rd_data, e.rdd);
      chk("R7", "req_ready", req_ready, (!busy && !m_pend) ? 1 : 0);

      // Decide what the next cycles hold (R8: refresh ahead of requests).
      if (!busy) begin
        if (m_pend) begin
          v = quiet(); v.is_ref = 1; v.ras_n = 0; v.chk_addr = 1; v.addr = 11'(m_rrow);
          q.push_back(v); q.push_back(v);
          v = quiet(); v.is_ref = 1;
          q.push_back(v);
          clr_at = cyc + 3;
        end else if (req_valid) begin
          key = int'(req_addr);
          v = quiet(); v.ras_n = 0; v.chk_addr = 1; v.addr = req_addr[21:11];
          q.push_back(v);
          v = quiet(); v.ras_n = 0; v.cas_n = 0; v.chk_addr = 1; v.addr = req_addr[10:0];
          v.we_n = !req_write; v.oe_n = req_write; v.dq_oe = req_write; v.dq = req_wdata;
          q.push_back(v); q.push_back(v);
          v = quiet();
          if (!req_write) begin
            v.rdv = 1;
            v.rdd = mm.exists(key) ? mm[key] : 4'h0;
          end
          q.push_back(v);
          if (req_write) mm[key] = req_wdata;
        end
      end

      // End-of-cycle bookkeeping of the interval and the row number.
      if (cyc == clr_at) begin
        m_rrow = (m_rrow + 1) % NROWS;
        if (m_rrow == 0) n_wraps++;
      end
      if ((cyc % IV) == IV - 1) m_pend = 1;
      else if (cyc == clr_at) m_pend = 0;
      cyc++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input bit w, input logic [21:0] a, input logic [3:0] d);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    // R1: strobes held inactive during reset
    repeat (3) @(negedge clk);
    chk("R1", "ras_n in reset", dram_ras_n, 1);
    chk("R1", "cas_n in reset", dram_cas_n, 1);
    chk("R1", "we_n in reset", dram_we_n, 1);
    chk("R1", "oe_n in reset", dram_oe_n, 1);
    chk("R1", "dq_oe in reset", dram_dq_oe, 0);
    chk("R1", "rd_valid in reset", rd_valid, 0);
    @(posedge clk); #1;
    rst_n = 1;

    // R2 R3 R4 R5: corner addresses, distinct row and column halves
    issue(1, 22'h000000, 4'h5);
    issue(1, 22'h3FFFFF, 4'hA);
    issue(1, 22'h2AA555, 4'h3);
    issue(1, 22'h155AAA, 4'hC);
    issue(0, 22'h000000, 4'h0);
    issue(0, 22'h3FFFFF, 4'h0);
    issue(0, 22'h2AA555, 4'h0);
    issue(0, 22'h155AAA, 4'h0);
    issue(0, 22'h001800, 4'h0);   // never written: reads 0

    // R7: one-cycle request while busy is dropped; read-back shows no write
    issue(1, 22'h012345, 4'h9);
    req_valid = 1; req_write = 1; req_addr = 22'h0ABCDE; req_wdata = 4'h7;
    @(posedge clk); #1;
    req_valid = 0;
    idle(8);
    issue(0, 22'h0ABCDE, 4'h0);
    issue(0, 22'h012345, 4'h0);

    // R8: requests lined up back to back collide with refresh intervals
    for (int i = 0; i < 40; i++)
      issue(i[0], {11'(i * 37), 11'(i * 91)}, 4'(i));

    // Mixed traffic over a small address set so reads hit earlier writes
    for (int i = 0; i < 300; i++) begin
      issue(($urandom % 2) == 1,
            {9'd0, 2'($urandom), 9'd0, 2'($urandom)},
            4'($urandom));
      if ((i % 7) == 0) idle(int'($urandom % 20));
    end

    // R10: idle long enough for a full sweep of rows and a wrap to 0
    idle(NROWS * IV + 200);
    @(negedge clk);
    chk("R10", "row wraps seen", (n_wraps >= 1) ? 1 : 0, 1);
    finish_up();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

endmodule